// File: doc/BRIEF.md
# Masked Eight-Source Interrupt Combiner

This block gathers eight internal event conditions into a single active-low interrupt request for a host processor. The conditions are transmitter-ready and receiver-ready for two serial channels, a break-change event for each channel, a counter/timer terminal event, and a summary of input-pin level changes. The host reaches the block over a small synchronous read/write bus. Through that bus it sets an enable mask, reads the status of every source, acknowledges sticky events, and reads the per-pin change record.

Four sources are plain levels, and they are copied into status on every clock. The break and timer sources are sticky: a one-cycle set pulse latches them, and a host acknowledge clears them. The pin-change summary is the OR of four latched per-pin change flags, each gated by a per-pin enable. It tells the host that some enabled pin changed, but not which pin. The host finds the pin by reading the change record, and that read also clears it. Each of eight active-low discrete outputs carries either its own raw status bit or a general-purpose data bit, as chosen per bit by a configuration register. This lets the ready flags serve as request lines to a transfer engine.

Top module: `irq_combiner`

## Requirements
- R1: After a clock edge with rst_n low, irq_n is 1, dout_n is 8'hFF, and mask, enable, configuration and general-purpose registers read 0. With all event inputs low, status reads 0.
- R2: irq_n is 0 exactly when some status bit and the same mask bit are both 1. It follows the registered status and mask with no further delay.
- R3: Status bits 0, 1, 4 and 5 equal chan_lvl[0], chan_lvl[1], chan_lvl[2] and chan_lvl[3] as sampled at the previous clock edge. A write to address 0 leaves them unchanged.
- R4: A read of address 0 returns all eight status bits, whatever the mask holds.
- R5: Status bits 2, 3 and 6 are set by one-cycle pulses on brk_set_a, tmr_set and brk_set_b. Each stays set until a write to address 0 with a 1 in that bit position. A set pulse in the same cycle as its clear leaves the bit set.
- R6: A pulse on pin_chg[k] sets change flag k. A read of address 2 returns {4'b0, flags} and clears them on that edge, except for any flag pulsed in that same cycle.
- R7: Status bit 7 is 1 when any change flag is 1 together with its enable bit (address 3, bits 3:0).
- R8: The mask register at address 1 can be written and read back with all 8 bits.
- R9: dout_n[i] is ~status[i] when configuration bit i (address 4) is 1, and ~gpo[i] (address 5) otherwise. The mask has no effect on it.
- R10: Addresses 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| chan_lvl | input | 4 | Level sources {rx B, tx B, rx A, tx A} |
| brk_set_a | input | 1 | Break-change set pulse, channel A |
| brk_set_b | input | 1 | Break-change set pulse, channel B |
| tmr_set | input | 1 | Counter/timer terminal-event pulse |
| pin_chg | input | 4 | Per-pin change-detected pulses |
| irq_n | output | 1 | Combined interrupt request, active low |
| dout_n | output | 8 | Discrete outputs, active low |

## Verification
The assertions assume that set pulses and bus strobes are synchronous to clk and held for exactly one cycle. They also assume that bus_wr and bus_rd are never high together. The bench meets this by driving every input at the falling edge and returning each strobe and pulse to 0 at the next falling edge. Outputs are sampled only after that edge has settled. For the two same-cycle races that the requirements define, set against acknowledge and pulse against read, the bench drives both inputs within one low clock phase.

// File: rtl/icu_pkg.sv
// Shared constants for the interrupt combiner: bus addresses, status bit
// positions and widths. Assumes exactly eight status sources.
package icu_pkg;
    localparam int DW       = 8;
    localparam int AW       = 3;
    localparam int NUM_SRC  = 8;
    localparam int NUM_LVL  = 4;
    localparam int NUM_PIN  = 4;

    localparam logic [AW-1:0] A_STAT = 3'd0;
    localparam logic [AW-1:0] A_MASK = 3'd1;
    localparam logic [AW-1:0] A_PCHG = 3'd2;
    localparam logic [AW-1:0] A_PEN  = 3'd3;
    localparam logic [AW-1:0] A_OCFG = 3'd4;
    localparam logic [AW-1:0] A_GPO  = 3'd5;

    localparam int B_TXA = 0;
    localparam int B_RXA = 1;
    localparam int B_BKA = 2;
    localparam int B_TMR = 3;
    localparam int B_TXB = 4;
    localparam int B_RXB = 5;
    localparam int B_BKB = 6;
    localparam int B_COS = 7;

    typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/icu_events.sv
// Event capture for the combiner. Registers the level sources, keeps the
// sticky sources and the per-pin change flags, and forms the 8-bit status.
// Assumes set pulses and clear strobes are one cycle long and synchronous.
module icu_events
    import icu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] lvl_in,
    input  logic               set_bka,
    input  logic               set_bkb,
    input  logic               set_tmr,
    input  logic [NUM_PIN-1:0] pin_pulse,
    input  logic               ack_we,
    input  word_t              ack_bits,
    input  logic               chg_rd,
    input  logic [NUM_PIN-1:0] pin_en,
    output word_t              status,
    output logic [NUM_PIN-1:0] chg
);
    logic [NUM_LVL-1:0] lvl_q;
    logic               bka_q, bkb_q, tmr_q;
    logic [NUM_PIN-1:0] chg_q;

    // sample the level sources once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_in;
    end

    // sticky sources: a set pulse wins over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bka_q <= 1'b0;
            bkb_q <= 1'b0;
            tmr_q <= 1'b0;
        end else begin
            bka_q <= set_bka | (bka_q & ~(ack_we & ack_bits[B_BKA]));
            bkb_q <= set_bkb | (bkb_q & ~(ack_we & ack_bits[B_BKB]));
            tmr_q <= set_tmr | (tmr_q & ~(ack_we & ack_bits[B_TMR]));
        end
    end

    // per-pin change flags, cleared by a read of the change record
    always_ff @(posedge clk) begin
        if (!rst_n)      chg_q <= '0;
        else if (chg_rd) chg_q <= pin_pulse;
        else             chg_q <= chg_q | pin_pulse;
    end

    // assemble the status word in its fixed bit order
    always_comb begin
        status        = '0;
        status[B_TXA] = lvl_q[0];
        status[B_RXA] = lvl_q[1];
        status[B_TXB] = lvl_q[2];
        status[B_RXB] = lvl_q[3];
        status[B_BKA] = bka_q;
        status[B_BKB] = bkb_q;
        status[B_TMR] = tmr_q;
        status[B_COS] = |(chg_q & pin_en);
    end

    assign chg = chg_q;
endmodule

// File: rtl/icu_regfile.sv
// Host register file of the combiner: mask, pin enable, output configuration
// and general-purpose output data, plus the read multiplexer and the
// side-effect strobes. Assumes bus_wr and bus_rd are never high together.
module icu_regfile
    import icu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      addr,
    input  logic               wr,
    input  logic               rd,
    input  word_t              wdata,
    output word_t              rdata,
    input  word_t              status,
    input  logic [NUM_PIN-1:0] chg,
    output word_t              mask,
    output logic [NUM_PIN-1:0] pin_en,
    output word_t              ocfg,
    output word_t              gpo,
    output logic               ack_we,
    output logic               chg_rd
);
    word_t              mask_q, ocfg_q, gpo_q;
    logic [NUM_PIN-1:0] pen_q;

    // host writes to the configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pen_q  <= '0;
            ocfg_q <= '0;
            gpo_q  <= '0;
        end else if (wr) begin
            case (addr)
                A_MASK:  mask_q <= wdata;
                A_PEN:   pen_q  <= wdata[NUM_PIN-1:0];
                A_OCFG:  ocfg_q <= wdata;
                A_GPO:   gpo_q  <= wdata;
                default: ;
            endcase
        end
    end

    // read data selection, zero on unmapped addresses
    always_comb begin
        case (addr)
            A_STAT:  rdata = status;
            A_MASK:  rdata = mask_q;
            A_PCHG:  rdata = {{(DW-NUM_PIN){1'b0}}, chg};
            A_PEN:   rdata = {{(DW-NUM_PIN){1'b0}}, pen_q};
            A_OCFG:  rdata = ocfg_q;
            A_GPO:   rdata = gpo_q;
            default: rdata = '0;
        endcase
    end

    assign ack_we = wr & (addr == A_STAT);
    assign chg_rd = rd & (addr == A_PCHG);
    assign mask   = mask_q;
    assign pin_en = pen_q;
    assign ocfg   = ocfg_q;
    assign gpo    = gpo_q;
endmodule

// File: rtl/icu_dout.sv
// Discrete output stage: each active-low pin carries its raw status bit when
// configured, otherwise the general-purpose data bit. Purely combinational.
module icu_dout
    import icu_pkg::*;
(
    input  word_t status,
    input  word_t ocfg,
    input  word_t gpo,
    output word_t pin_n
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pin
        // choose function or data per pin, then invert
        assign pin_n[i] = ~(ocfg[i] ? status[i] : gpo[i]);
    end
endmodule

// File: rtl/irq_combiner.sv
// Top of the masked eight-source interrupt combiner. Joins event capture,
// the register file and the discrete outputs; drives the active-low request
// from registered status and mask. Synchronous active-low reset.
module irq_combiner
    import icu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NUM_LVL-1:0] chan_lvl,
    input  logic               brk_set_a,
    input  logic               brk_set_b,
    input  logic               tmr_set,
    input  logic [NUM_PIN-1:0] pin_chg,
    output logic               irq_n,
    output logic [DW-1:0]      dout_n
);
    word_t              status_w, mask_w, ocfg_w, gpo_w;
    logic [NUM_PIN-1:0] chg_w, pen_w;
    logic               ack_we_w, chg_rd_w;

    icu_events u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_in    (chan_lvl),
        .set_bka   (brk_set_a),
        .set_bkb   (brk_set_b),
        .set_tmr   (tmr_set),
        .pin_pulse (pin_chg),
        .ack_we    (ack_we_w),
        .ack_bits  (bus_wdata),
        .chg_rd    (chg_rd_w),
        .pin_en    (pen_w),
        .status    (status_w),
        .chg       (chg_w)
    );

    icu_regfile u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .status (status_w),
        .chg    (chg_w),
        .mask   (mask_w),
        .pin_en (pen_w),
        .ocfg   (ocfg_w),
        .gpo    (gpo_w),
        .ack_we (ack_we_w),
        .chg_rd (chg_rd_w)
    );

    icu_dout u_out (
        .status (status_w),
        .ocfg   (ocfg_w),
        .gpo    (gpo_w),
        .pin_n  (dout_n)
    );

    // request is low while any enabled source is active
    assign irq_n = ~|(status_w & mask_w);
endmodule

// File: rtl/irq_combiner_chk.sv
// Assertion checker for irq_combiner, bound into the top. Assumes one-cycle
// strobes and pulses driven synchronously to clk.
module irq_combiner_chk
    import icu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      bus_addr,
    input logic               bus_wr,
    input logic [DW-1:0]      bus_wdata,
    input logic [NUM_LVL-1:0] chan_lvl,
    input logic               tmr_set,
    input logic               irq_n,
    input logic [DW-1:0]      dout_n,
    input logic [DW-1:0]      status,
    input logic [DW-1:0]      mask
);
    // R1: reset drives the request and the pins inactive
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (irq_n && dout_n == 8'hFF));

    // R2: with nothing enabled the request stays inactive
    a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'h00) |-> irq_n);

    // R3: level sources follow their inputs one clock later
    a_r3_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (status[B_TXA] == $past(chan_lvl[0])
                   && status[B_RXB] == $past(chan_lvl[3])));

    // R5: a timer pulse sets the sticky bit
    a_r5_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_set |=> status[B_TMR]);

    // R5: the sticky bit holds without an acknowledge of that bit
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_TMR] && !(bus_wr && bus_addr == A_STAT && bus_wdata[B_TMR]))
        |=> status[B_TMR]);
endmodule

bind irq_combiner irq_combiner_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .chan_lvl  (chan_lvl),
    .tmr_set   (tmr_set),
    .irq_n     (irq_n),
    .dout_n    (dout_n),
    .status    (status_w),
    .mask      (mask_w)
);

// File: tb/sim_irq_combiner.sv
module sim_irq_combiner;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {chan_lvl, mask, expected status, expected irq_n}
    localparam logic [20:0] VEC [NVEC] = '{
        {4'b0000, 8'hFF, 8'h00, 1'b1},
        {4'b0001, 8'h00, 8'h01, 1'b1},
        {4'b0001, 8'h01, 8'h01, 1'b0},
        {4'b0110, 8'h01, 8'h12, 1'b1},
        {4'b1000, 8'h20, 8'h20, 1'b0},
        {4'b1111, 8'hCC, 8'h33, 1'b1},
        {4'b0100, 8'h10, 8'h10, 1'b0}
    };

    logic       clk = 0, rst_n = 0;
    logic [2:0] bus_addr = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [3:0] chan_lvl = 0;
    logic       brk_set_a = 0, brk_set_b = 0, tmr_set = 0;
    logic [3:0] pin_chg = 0;
    logic       irq_n;
    logic [7:0] dout_n;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] rv;

    irq_combiner u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);
        check("R1 dout_n", dout_n, 8'hFF);
        rd(3'd1, rv); check("R1 mask", rv, 8'h00);
        rd(3'd4, rv); check("R1 ocfg", rv, 8'h00);
        rd(3'd0, rv); check("R1 status", rv, 8'h00);

        // R2 R3 R4: vector walk of levels against masks
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk); chan_lvl = VEC[i][20:17];
            wr(3'd1, VEC[i][16:9]);
            rd(3'd0, rv);
            check("R4 status vector", rv, VEC[i][8:1]);
            check("R2 irq_n vector", {7'b0, irq_n}, {7'b0, VEC[i][0]});
        end
        chan_lvl = 0;
        wr(3'd1, 8'h00);
        rd(3'd1, rv); check("R8 mask readback", rv, 8'h00);
        wr(3'd1, 8'hA5); rd(3'd1, rv); check("R8 mask readback", rv, 8'hA5);
        wr(3'd1, 8'h00);

        // R5 sticky timer bit
        @(negedge clk); tmr_set = 1; @(negedge clk); tmr_set = 0;
        rd(3'd0, rv); check("R5 timer set", rv, 8'h08);
        check("R2 masked off", {7'b0, irq_n}, 8'h01);
        wr(3'd1, 8'h08);
        check("R2 enabled", {7'b0, irq_n}, 8'h00);
        chan_lvl = 4'b0001;
        wr(3'd0, 8'hF7);
        rd(3'd0, rv); check("R5 hold without ack, R3 level kept", rv, 8'h09);
        // R5 set wins over clear in the same cycle
        @(negedge clk); bus_addr = 0; bus_wdata = 8'h08; bus_wr = 1; tmr_set = 1;
        @(negedge clk); bus_wr = 0; tmr_set = 0;
        rd(3'd0, rv); check("R5 set beats clear", rv, 8'h09);
        wr(3'd0, 8'h08);
        rd(3'd0, rv); check("R5 cleared", rv, 8'h01);
        check("R2 after clear", {7'b0, irq_n}, 8'h01);
        chan_lvl = 0;
        @(negedge clk); brk_set_a = 1; brk_set_b = 1;
        @(negedge clk); brk_set_a = 0; brk_set_b = 0;
        rd(3'd0, rv); check("R5 break bits", rv, 8'h44);
        wr(3'd0, 8'h04);
        rd(3'd0, rv); check("R5 break A cleared", rv, 8'h40);
        wr(3'd0, 8'h40);

        // R6 R7 pin change flags and summary
        @(negedge clk); pin_chg = 4'b0100; @(negedge clk); pin_chg = 0;
        rd(3'd0, rv); check("R7 disabled pin", rv, 8'h00);
        wr(3'd3, 8'h04);
        rd(3'd0, rv); check("R7 summary set", rv, 8'h80);
        rd(3'd2, rv); check("R6 change record", rv, 8'h04);
        rd(3'd2, rv); check("R6 cleared by read", rv, 8'h00);
        rd(3'd0, rv); check("R7 summary clear", rv, 8'h00);
        @(negedge clk); bus_addr = 2; bus_rd = 1; pin_chg = 4'b0010;
        @(negedge clk); bus_rd = 0; pin_chg = 0;
        rd(3'd2, rv); check("R6 pulse during read", rv, 8'h02);

        // R9 discrete outputs
        wr(3'd4, 8'h0F); wr(3'd5, 8'hA0);
        @(negedge clk); tmr_set = 1; @(negedge clk); tmr_set = 0;
        check("R9 dout mix", dout_n, 8'h57);
        wr(3'd1, 8'hFF);
        check("R9 mask no effect", dout_n, 8'h57);
        wr(3'd0, 8'h08);
        check("R9 after clear", dout_n, 8'h5F);

        // R10 unmapped addresses
        wr(3'd6, 8'hFF);
        rd(3'd6, rv); check("R10 read zero", rv, 8'h00);
        rd(3'd1, rv); check("R10 mask untouched", rv, 8'hFF);
        rd(3'd5, rv); check("R10 gpo untouched", rv, 8'hA0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule